// File: doc/BRIEF.md
# Serial Transceiver Channel Reset Sequencer

This block brings one serial transceiver channel out of reset in a safe order. It watches three status inputs: the transmit PLL lock indicator, the reconfiguration busy flag and the receiver frequency-lock flag. From them it drives the transmit digital reset, the receiver analog reset and the receiver digital reset. It also drives the two CDR steering controls, one that makes the CDR track the reference clock and one that makes it track the incoming data. Each status input passes through a two-flop synchronizer before the sequencer uses it.

A parameter selects the channel configuration: transmit only, receive only, or both directions. A second parameter selects the CDR lock mode. In automatic mode the CDR switches itself over, and the sequencer only waits for a stable frequency lock. In manual mode the sequencer moves the CDR from reference tracking to data tracking, then waits a minimum dwell time before it releases the receiver. For a group of non-bonded channels, place one instance per channel; each instance runs its sequence independently. A `ready_o` flag reports that every enabled direction has finished its release sequence.

Top module: `chan_rst_seq`

## Requirements
- R1: While `arst_ni` is low, every reset output is 1, `ready_o` is 0 and `cdr_lock_data_o` is 0, with no clock edge needed. `cdr_lock_ref_o` is 1 when manual lock mode is selected and the receiver is enabled, and 0 otherwise.
- R2: Each status input is synchronized by two flops, so an output reacts no earlier than the third rising clock edge after the input changes.
- R3: `tx_dig_rst_o` stays 1 until the synchronized PLL lock is seen high. It falls at the third rising edge after `pll_locked_i` rises.
- R4: `rx_ana_rst_o` falls exactly two cycles after the sequencer first sees PLL locked and busy low. If busy returns high during those two cycles, the wait starts over.
- R5: In automatic mode, `rx_dig_rst_o` falls only after the synchronized frequency lock has been high for SETTLE_CYC consecutive cycles. Any low cycle restarts the count.
- R6: In manual mode, `cdr_lock_ref_o` stays 1 until frequency lock is seen. In that same cycle `cdr_lock_ref_o` drops and `cdr_lock_data_o` rises. The two controls are never 1 together.
- R7: In manual mode, `rx_dig_rst_o` falls exactly LTD_WAIT cycles after `cdr_lock_data_o` rises.
- R8: Either of two events sends the channel back to the full reset state, after which the whole sequence restarts: PLL lock dropping at any time, or frequency lock dropping after the receiver has been released.
- R9: In the transmit-only configuration, both receiver resets stay 1 and both CDR controls stay 0. In the receive-only configuration, `tx_dig_rst_o` stays 1.
- R10: `ready_o` is 1 exactly when every enabled direction has released its digital reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Parallel clock of the channel |
| arst_ni | input | 1 | Asynchronous reset, active low |
| pll_locked_i | input | 1 | Transmit PLL lock status, asynchronous |
| busy_i | input | 1 | Reconfiguration busy status, asynchronous |
| freq_locked_i | input | 1 | Receiver CDR frequency-lock status, asynchronous |
| tx_dig_rst_o | output | 1 | Transmit digital reset, active high |
| rx_ana_rst_o | output | 1 | Receiver analog reset, active high |
| rx_dig_rst_o | output | 1 | Receiver digital reset, active high |
| cdr_lock_ref_o | output | 1 | Makes the CDR track the reference clock |
| cdr_lock_data_o | output | 1 | Makes the CDR track the incoming data |
| ready_o | output | 1 | All enabled directions are released |

## Verification
The hardest cases to reach from the ports are the ones that need a status input high for only a cycle or two, because a restart can then only be observed as a release that never happens. Two such cases matter: a busy flag that falls inside the two-cycle analog gap and rises again, and a frequency lock that stays high for fewer cycles than the settle count. The bench drives pulses whose length is counted in clock cycles at the pins, works out how many synchronized samples each pulse produces, and then checks that the release stays withheld for a long window afterwards. Four instances, one per configuration and lock mode, share the PLL and busy stimulus, so each check runs against every variant at once.

// File: rtl/csq_pkg.sv
package csq_pkg;
  typedef enum logic [1:0] {
    CFG_TX_ONLY = 2'd0,
    CFG_RX_ONLY = 2'd1,
    CFG_TX_RX   = 2'd2
  } chan_cfg_e;

  typedef enum logic [2:0] {
    RX_IDLE = 3'd0,
    RX_GAP  = 3'd1,
    RX_LOCK = 3'd2,
    RX_LTD  = 3'd3,
    RX_DONE = 3'd4
  } rx_state_e;

  function automatic bit has_tx(chan_cfg_e cfg);
    return cfg != CFG_RX_ONLY;
  endfunction

  function automatic bit has_rx(chan_cfg_e cfg);
    return cfg != CFG_TX_ONLY;
  endfunction

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // Width of a counter that reaches the largest window minus one.
  function automatic int unsigned win_width(int unsigned a, int unsigned b, int unsigned c);
    return (max3(a, b, c) < 2) ? 1 : $clog2(max3(a, b, c));
  endfunction
endpackage

// File: rtl/csq_sync.sv
module csq_sync #(
  parameter int unsigned W = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         arst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic meta_q, stab_q;
    always_ff @(posedge clk_i or negedge arst_ni) begin
      if (!arst_ni) begin
        meta_q <= RST_VAL[b];
        stab_q <= RST_VAL[b];
      end else begin
        meta_q <= async_i[b];
        stab_q <= meta_q;
      end
    end
    assign sync_o[b] = stab_q;
  end
endmodule

// File: rtl/csq_tx_ctl.sv
module csq_tx_ctl #(
  parameter bit EN = 1'b1
) (
  input  logic clk_i,
  input  logic arst_ni,
  input  logic pll_s_i,
  output logic tx_rst_o,
  output logic tx_done_o
);
  logic rst_q;
  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) rst_q <= 1'b1;
    else          rst_q <= EN ? !pll_s_i : 1'b1;
  end
  assign tx_rst_o  = rst_q;
  assign tx_done_o = EN && !rst_q;
endmodule

// File: rtl/csq_rx_ctl.sv
module csq_rx_ctl
  import csq_pkg::*;
#(
  parameter bit          EN         = 1'b1,
  parameter bit          MANUAL     = 1'b1,
  parameter int unsigned GAP_CYC    = 2,
  parameter int unsigned SETTLE_CYC = 8,
  parameter int unsigned LTD_WAIT   = 16
) (
  input  logic clk_i,
  input  logic arst_ni,
  input  logic pll_s_i,
  input  logic busy_s_i,
  input  logic freq_s_i,
  output logic ana_rst_o,
  output logic dig_rst_o,
  output logic lock_ref_o,
  output logic lock_data_o,
  output logic rx_done_o
);
  localparam int unsigned CW = win_width(GAP_CYC, SETTLE_CYC, LTD_WAIT);
  localparam logic [CW-1:0] GAP_LAST    = CW'(GAP_CYC - 1);
  localparam logic [CW-1:0] SETTLE_LAST = CW'(SETTLE_CYC - 1);
  localparam logic [CW-1:0] LTD_LAST    = CW'(LTD_WAIT - 1);

  rx_state_e st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      RX_IDLE: if (!busy_s_i) begin st_d = RX_GAP; cnt_d = '0; end
      RX_GAP: begin
        if (busy_s_i)               st_d = RX_IDLE;
        else if (cnt_q == GAP_LAST) begin st_d = RX_LOCK; cnt_d = '0; end
        else                        cnt_d = cnt_q + CW'(1);
      end
      RX_LOCK: begin
        if (MANUAL) begin
          if (freq_s_i) begin st_d = RX_LTD; cnt_d = '0; end
        end else if (!freq_s_i)        cnt_d = '0;
        else if (cnt_q == SETTLE_LAST) st_d = RX_DONE;
        else                           cnt_d = cnt_q + CW'(1);
      end
      RX_LTD: begin
        if (cnt_q == LTD_LAST) st_d = RX_DONE;
        else                   cnt_d = cnt_q + CW'(1);
      end
      RX_DONE: if (!freq_s_i) st_d = RX_IDLE;
      default: st_d = RX_IDLE;
    endcase
    // Lost PLL lock, or a disabled receiver, pins the path in reset.
    if (!pll_s_i || !EN) begin
      st_d  = RX_IDLE;
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      st_q  <= RX_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign ana_rst_o   = (st_q == RX_IDLE) || (st_q == RX_GAP);
  assign dig_rst_o   = (st_q != RX_DONE);
  assign lock_ref_o  = EN && MANUAL && (st_q inside {RX_IDLE, RX_GAP, RX_LOCK});
  assign lock_data_o = MANUAL && (st_q inside {RX_LTD, RX_DONE});
  assign rx_done_o   = (st_q == RX_DONE);
endmodule

// File: rtl/chan_rst_seq.sv
module chan_rst_seq
  import csq_pkg::*;
#(
  parameter chan_cfg_e   CFG         = CFG_TX_RX,
  parameter bit          MANUAL_LOCK = 1'b1,
  parameter int unsigned GAP_CYC     = 2,
  parameter int unsigned SETTLE_CYC  = 8,
  parameter int unsigned LTD_WAIT    = 16
) (
  input  logic clk_i,
  input  logic arst_ni,
  input  logic pll_locked_i,
  input  logic busy_i,
  input  logic freq_locked_i,
  output logic tx_dig_rst_o,
  output logic rx_ana_rst_o,
  output logic rx_dig_rst_o,
  output logic cdr_lock_ref_o,
  output logic cdr_lock_data_o,
  output logic ready_o
);
  localparam bit TX_EN = has_tx(CFG);
  localparam bit RX_EN = has_rx(CFG);
  // Bit order: 0 PLL lock, 1 busy, 2 frequency lock; busy resets to 1.
  localparam logic [2:0] SYNC_RST = 3'b010;

  logic [2:0] stat_s;
  logic pll_s, busy_s, freq_s;
  logic tx_done, rx_done;

  csq_sync #(.W(3), .RST_VAL(SYNC_RST)) sync_i (
    .clk_i(clk_i), .arst_ni(arst_ni),
    .async_i({freq_locked_i, busy_i, pll_locked_i}),
    .sync_o(stat_s)
  );
  assign pll_s  = stat_s[0];
  assign busy_s = stat_s[1];
  assign freq_s = stat_s[2];

  csq_tx_ctl #(.EN(TX_EN)) tx_i (
    .clk_i(clk_i), .arst_ni(arst_ni), .pll_s_i(pll_s),
    .tx_rst_o(tx_dig_rst_o), .tx_done_o(tx_done)
  );

  csq_rx_ctl #(
    .EN(RX_EN), .MANUAL(MANUAL_LOCK), .GAP_CYC(GAP_CYC),
    .SETTLE_CYC(SETTLE_CYC), .LTD_WAIT(LTD_WAIT)
  ) rx_i (
    .clk_i(clk_i), .arst_ni(arst_ni),
    .pll_s_i(pll_s), .busy_s_i(busy_s), .freq_s_i(freq_s),
    .ana_rst_o(rx_ana_rst_o), .dig_rst_o(rx_dig_rst_o),
    .lock_ref_o(cdr_lock_ref_o), .lock_data_o(cdr_lock_data_o),
    .rx_done_o(rx_done)
  );

  assign ready_o = (!TX_EN || tx_done) && (!RX_EN || rx_done);
endmodule

// File: rtl/chan_rst_seq_chk.sv
module chan_rst_seq_chk #(
  parameter bit          TX_EN    = 1'b1,
  parameter bit          RX_EN    = 1'b1,
  parameter bit          MANUAL   = 1'b1,
  parameter int unsigned LTD_WAIT = 16
) (
  input logic clk_i,
  input logic arst_ni,
  input logic pll_s,
  input logic busy_s,
  input logic tx_dig_rst_o,
  input logic rx_ana_rst_o,
  input logic rx_dig_rst_o,
  input logic cdr_lock_ref_o,
  input logic cdr_lock_data_o,
  input logic ready_o
);
  logic [15:0] ltd_cnt_q;
  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni)                            ltd_cnt_q <= '0;
    else if (!cdr_lock_data_o)               ltd_cnt_q <= '0;
    else if (ltd_cnt_q != 16'hffff)          ltd_cnt_q <= ltd_cnt_q + 16'd1;
  end

  assert_tx_needs_pll_R3: assert property (@(posedge clk_i) disable iff (!arst_ni)
    $fell(tx_dig_rst_o) |-> $past(pll_s));

  assert_ana_gap_R4: assert property (@(posedge clk_i) disable iff (!arst_ni)
    $fell(rx_ana_rst_o) |-> (!$past(busy_s, 1) && !$past(busy_s, 2) && !$past(busy_s, 3)));

  assert_cdr_excl_R6: assert property (@(posedge clk_i) disable iff (!arst_ni)
    !(cdr_lock_ref_o && cdr_lock_data_o));

  assert_ltd_dwell_R7: assert property (@(posedge clk_i) disable iff (!arst_ni)
    (MANUAL && $fell(rx_dig_rst_o)) |-> (32'(ltd_cnt_q) >= LTD_WAIT - 1));

  assert_pll_restart_R8: assert property (@(posedge clk_i) disable iff (!arst_ni)
    $fell(pll_s) |=> (tx_dig_rst_o && rx_ana_rst_o && rx_dig_rst_o && !ready_o));

  assert_ready_R10: assert property (@(posedge clk_i) disable iff (!arst_ni)
    ready_o |-> ((!TX_EN || !tx_dig_rst_o) && (!RX_EN || !rx_dig_rst_o)));

  assert_rx_off_R9: assert property (@(posedge clk_i) disable iff (!arst_ni)
    !RX_EN |-> (rx_ana_rst_o && rx_dig_rst_o && !cdr_lock_ref_o && !cdr_lock_data_o));
endmodule

bind chan_rst_seq chan_rst_seq_chk #(
  .TX_EN(TX_EN), .RX_EN(RX_EN), .MANUAL(MANUAL_LOCK), .LTD_WAIT(LTD_WAIT)
) chk_i (
  .clk_i(clk_i), .arst_ni(arst_ni), .pll_s(pll_s), .busy_s(busy_s),
  .tx_dig_rst_o(tx_dig_rst_o), .rx_ana_rst_o(rx_ana_rst_o),
  .rx_dig_rst_o(rx_dig_rst_o), .cdr_lock_ref_o(cdr_lock_ref_o),
  .cdr_lock_data_o(cdr_lock_data_o), .ready_o(ready_o)
);

// File: tb/chan_rst_seq_tb_top.sv
`timescale 1ns/1ps
module chan_rst_seq_tb_top;
  import csq_pkg::*;
  localparam int unsigned SETTLE = 3;
  localparam int unsigned LTD    = 4;

  logic clk = 1'b0;
  logic arst_n, pll, busy, fl_m, fl_a;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  // dut_i: both directions, manual; m_a: both, automatic; m_t: tx only; m_r: rx only, automatic
  logic i_tx, i_ana, i_dig, i_ref, i_dat, i_rdy;
  logic a_tx, a_ana, a_dig, a_ref, a_dat, a_rdy;
  logic t_tx, t_ana, t_dig, t_ref, t_dat, t_rdy;
  logic r_tx, r_ana, r_dig, r_ref, r_dat, r_rdy;

  chan_rst_seq #(.CFG(CFG_TX_RX), .MANUAL_LOCK(1'b1), .SETTLE_CYC(SETTLE), .LTD_WAIT(LTD)) dut_i (
    .clk_i(clk), .arst_ni(arst_n), .pll_locked_i(pll), .busy_i(busy), .freq_locked_i(fl_m),
    .tx_dig_rst_o(i_tx), .rx_ana_rst_o(i_ana), .rx_dig_rst_o(i_dig),
    .cdr_lock_ref_o(i_ref), .cdr_lock_data_o(i_dat), .ready_o(i_rdy));
  chan_rst_seq #(.CFG(CFG_TX_RX), .MANUAL_LOCK(1'b0), .SETTLE_CYC(SETTLE), .LTD_WAIT(LTD)) dut_auto (
    .clk_i(clk), .arst_ni(arst_n), .pll_locked_i(pll), .busy_i(busy), .freq_locked_i(fl_a),
    .tx_dig_rst_o(a_tx), .rx_ana_rst_o(a_ana), .rx_dig_rst_o(a_dig),
    .cdr_lock_ref_o(a_ref), .cdr_lock_data_o(a_dat), .ready_o(a_rdy));
  chan_rst_seq #(.CFG(CFG_TX_ONLY), .MANUAL_LOCK(1'b1), .SETTLE_CYC(SETTLE), .LTD_WAIT(LTD)) dut_tx (
    .clk_i(clk), .arst_ni(arst_n), .pll_locked_i(pll), .busy_i(busy), .freq_locked_i(fl_m),
    .tx_dig_rst_o(t_tx), .rx_ana_rst_o(t_ana), .rx_dig_rst_o(t_dig),
    .cdr_lock_ref_o(t_ref), .cdr_lock_data_o(t_dat), .ready_o(t_rdy));
  chan_rst_seq #(.CFG(CFG_RX_ONLY), .MANUAL_LOCK(1'b0), .SETTLE_CYC(SETTLE), .LTD_WAIT(LTD)) dut_rx (
    .clk_i(clk), .arst_ni(arst_n), .pll_locked_i(pll), .busy_i(busy), .freq_locked_i(fl_a),
    .tx_dig_rst_o(r_tx), .rx_ana_rst_o(r_ana), .rx_dig_rst_o(r_dig),
    .cdr_lock_ref_o(r_ref), .cdr_lock_data_o(r_dat), .ready_o(r_rdy));

  task automatic tick(int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  initial begin
    pll = 0; busy = 1; fl_m = 0; fl_a = 0; arst_n = 0;
    tick(3);
    chk("R1", "tx rst", i_tx, 1); chk("R1", "ana rst", i_ana, 1);
    chk("R1", "dig rst", i_dig, 1); chk("R1", "lock_ref manual", i_ref, 1);
    chk("R1", "lock_data", i_dat, 0); chk("R1", "ready", i_rdy, 0);
    chk("R1", "lock_ref auto", a_ref, 0);
    arst_n = 1;
    tick(4);
    chk("R3", "tx held without pll", i_tx, 1);

    pll = 1;
    tick(2);
    chk("R2", "tx not yet released", i_tx, 1);
    tick(1);
    chk("R3", "tx released third edge", i_tx, 0);
    chk("R10", "tx-only ready", t_rdy, 1);
    chk("R9", "rx-only tx held", r_tx, 1);
    chk("R4", "ana held while busy", i_ana, 1);
    chk("R10", "both-mode ready while rx in reset", i_rdy, 0);

    // one-cycle busy drop: gap entered then aborted
    busy = 0; tick(1); busy = 1;
    tick(8);
    chk("R4", "ana held after busy glitch (manual)", i_ana, 1);
    chk("R4", "ana held after busy glitch (auto)", a_ana, 1);

    busy = 0;
    tick(4);
    chk("R4", "ana before gap end", i_ana, 1);
    tick(1);
    chk("R4", "ana released (manual)", i_ana, 0);
    chk("R4", "ana released (auto)", a_ana, 0);
    chk("R4", "ana released (rx-only)", r_ana, 0);
    chk("R9", "tx-only ana held", t_ana, 1);
    chk("R9", "tx-only dig held", t_dig, 1);
    chk("R9", "tx-only lock_ref idle", t_ref, 0);
    chk("R9", "tx-only lock_data idle", t_dat, 0);
    chk("R6", "lock_ref before freq", i_ref, 1);

    // frequency lock high for two synchronized samples only (< SETTLE)
    fl_a = 1; tick(2); fl_a = 0;
    tick(8);
    chk("R5", "dig held after short lock", a_dig, 1);
    chk("R5", "ready low after short lock", a_rdy, 0);
    fl_a = 1;
    tick(4);
    chk("R5", "dig before settle end", a_dig, 1);
    tick(1);
    chk("R5", "dig released after settle", a_dig, 0);
    chk("R10", "auto ready", a_rdy, 1);
    chk("R10", "rx-only ready", r_rdy, 1);
    chk("R5", "auto lock_data stays low", a_dat, 0);

    fl_m = 1;
    tick(2);
    chk("R6", "lock_ref still high", i_ref, 1);
    tick(1);
    chk("R6", "lock_ref dropped", i_ref, 0);
    chk("R6", "lock_data raised", i_dat, 1);
    chk("R7", "dig held at ltd start", i_dig, 1);
    tick(LTD - 1);
    chk("R7", "dig held one before dwell", i_dig, 1);
    tick(1);
    chk("R7", "dig released after dwell", i_dig, 0);
    chk("R10", "manual ready", i_rdy, 1);

    fl_m = 0;
    tick(2);
    chk("R8", "dig before freq loss seen", i_dig, 0);
    tick(1);
    chk("R8", "dig after freq loss", i_dig, 1);
    chk("R8", "ana after freq loss", i_ana, 1);
    chk("R8", "lock_ref back", i_ref, 1);
    chk("R8", "lock_data cleared", i_dat, 0);
    chk("R8", "ready cleared", i_rdy, 0);
    chk("R8", "other channel unaffected", a_rdy, 1);

    pll = 0;
    tick(2);
    chk("R8", "tx before pll loss seen", a_tx, 0);
    tick(1);
    chk("R8", "tx after pll loss", a_tx, 1);
    chk("R8", "ana after pll loss", a_ana, 1);
    chk("R8", "dig after pll loss", a_dig, 1);
    chk("R8", "auto ready after pll loss", a_rdy, 0);
    chk("R8", "tx-only ready after pll loss", t_rdy, 0);

    pll = 1;
    tick(20);
    chk("R8", "auto resequenced", a_rdy, 1);
    #2 arst_n = 0;
    #1;
    chk("R1", "async tx", a_tx, 1); chk("R1", "async ana", a_ana, 1);
    chk("R1", "async dig", a_dig, 1); chk("R1", "async ready", a_rdy, 0);
    @(negedge clk);
    arst_n = 1;
    tick(2);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule